// File: doc/BRIEF.md
# Dual-Input Local Interrupt Controller

This block merges two local interrupt request pins into a single active-low level interrupt toward a host bus. One shared control/status word configures each input. Each input has an enable, a polarity select and a trigger-mode select. The word also holds a master output enable and a software interrupt request. Software reads the word back to poll a per-input status bit. It writes one-shot clear bits to acknowledge latched edges.

Each raw input first passes through a two-flop synchronizer. After that it is treated in one of two ways. A level-mode input shows its status while the source is active. A qualified edge-mode input latches on a rising edge and holds the latch until it is cleared or the input is disabled. The output is driven low while the master enable is set and either an enabled status bit or the software request is active.

The bit layout is fixed for two inputs. Input 1 (pin `irq_in[0]`) has enable bit 0, polarity bit 1, status bit 2, edge-select bit 8 and clear bit 10. Input 2 (pin `irq_in[1]`) has enable bit 3, polarity bit 4, status bit 5, edge-select bit 9 and clear bit 11. Bit 6 is the master enable and bit 7 is the software request. Bits 12 to 15 are unused.

Top module: `lirq_ctrl`

## Requirements
- R1: After reset every bit of `rd_data` reads 0 and `irq_n` is 1.
- R2: A write stores bits 0, 1, 3, 4, 6, 7, 8 and 9. With both inputs low and both inputs set to edge mode, writing 0xFFFF reads back 0x03DB. Bits 12 to 15 always read 0.
- R3: In level mode with polarity 1 (active-high), a status bit follows its pin three rising edges after the pin changes. The status is not yet visible after two edges.
- R4: In level mode with polarity 0, the status is 1 while the synchronized pin is low.
- R5: A level-mode status returns to 0 once the source goes inactive. It also returns to 0 in the same write that clears the input's enable bit.
- R6: Edge mode is in effect only when the edge-select, polarity and enable bits are all 1. With only the edge-select bit set and polarity 0, the input stays in level mode. In edge mode the status sets on a synchronized rising edge and stays set after the pin falls.
- R7: Writing 1 to clear bit 10 (input 1) or bit 11 (input 2) resets a latched edge status. The other fields written in the same word still take effect. Both clear bits always read 0.
- R8: When a clear write and a new synchronized rising edge act on the same clock edge, the status stays 1.
- R9: A write that clears the enable of an edge-mode input resets its latched status in that same write.
- R10: `irq_n` is 0 exactly when the master enable is 1 and either some enabled input's status is 1 or bit 7 is 1.
- R11: With the master enable at 0, `irq_n` is 1. The status bits still read back their live values.
- R12: Writing bit 7 with the master enable set drives `irq_n` low from the clock edge that takes the write. With the master enable at 0, the same write leaves `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes `wr_data` into the control/status word on this edge |
| wr_data | input | 16 | Write data for the control/status word |
| rd_data | output | 16 | Live readback of the control/status word |
| irq_in | input | 2 | Raw local interrupt pins, asynchronous |
| irq_n | output | 1 | Active-low level interrupt toward the host |

## Verification
Two events can land on the same clock edge: a software write-one clear of a latched edge status, and a fresh rising edge on that input. The bench raises the pin two edges ahead of a clear write, so the synchronized rise and the clear are both sampled on the third edge. It then expects the status to read 1 and `irq_n` to be low. A second clear with no rise pending must then read the status as 0. This shows that the first result came from the collision rule and not from a clear bit that failed to act.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned BIT_MASTER = 6;
    localparam int unsigned BIT_SWI    = 7;
    localparam int unsigned BIT_EDGE0  = 8;
    localparam int unsigned BIT_CLR0   = BIT_EDGE0 + NUM_CH;

    typedef struct packed {
        logic en;
        logic pol;
        logic edge_sel;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
        logic                   master;
        logic                   swi;
    } ctl_t;

    function automatic int unsigned pos_en(input int unsigned ch);
        return 3 * ch;
    endfunction

    function automatic int unsigned pos_pol(input int unsigned ch);
        return 3 * ch + 1;
    endfunction

    function automatic int unsigned pos_st(input int unsigned ch);
        return 3 * ch + 2;
    endfunction

    function automatic int unsigned pos_edge(input int unsigned ch);
        return BIT_EDGE0 + ch;
    endfunction

    function automatic int unsigned pos_clr(input int unsigned ch);
        return BIT_CLR0 + ch;
    endfunction

endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/lirq_chan.sv
module lirq_chan
    import lirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      src,      // synchronized pin
    input  chan_cfg_t cfg,      // configuration in force after this edge
    input  logic      clr,      // write-one clear pulse
    output logic      status
);
    typedef struct packed {
        logic s_prev;
        logic st;
    } chan_st_t;

    chan_st_t d, q;
    logic edge_mode, lvl_hit, rise;

    always_comb begin
        edge_mode = cfg.en & cfg.pol & cfg.edge_sel;
        lvl_hit   = cfg.pol ? src : ~src;
        rise      = src & ~q.s_prev;
        d         = q;
        d.s_prev  = src;
        if (!cfg.en)        d.st = 1'b0;
        else if (edge_mode) d.st = rise | (q.st & ~clr);  // new edge beats clear
        else                d.st = lvl_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status = q.st;
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
    import lirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] irq_in,
    output logic              irq_n
);
    ctl_t              ctl_d, ctl_q;
    logic [NUM_CH-1:0] src_s, clr_p, st;
    logic              req_any;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            lirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (irq_in[i]),
                .dout (src_s[i])
            );
            lirq_chan u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .src   (src_s[i]),
                .cfg   (ctl_d.cfg[i]),
                .clr   (clr_p[i]),
                .status(st[i])
            );
        end
    endgenerate

    always_comb begin
        ctl_d = ctl_q;
        clr_p = '0;
        if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                ctl_d.cfg[i].en       = wr_data[pos_en(i)];
                ctl_d.cfg[i].pol      = wr_data[pos_pol(i)];
                ctl_d.cfg[i].edge_sel = wr_data[pos_edge(i)];
                clr_p[i]              = wr_data[pos_clr(i)];
            end
            ctl_d.master = wr_data[BIT_MASTER];
            ctl_d.swi    = wr_data[BIT_SWI];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data = '0;
        req_any = ctl_q.swi;
        for (int i = 0; i < NUM_CH; i++) begin
            rd_data[pos_en(i)]   = ctl_q.cfg[i].en;
            rd_data[pos_pol(i)]  = ctl_q.cfg[i].pol;
            rd_data[pos_st(i)]   = st[i];
            rd_data[pos_edge(i)] = ctl_q.cfg[i].edge_sel;
            req_any              = req_any | (st[i] & ctl_q.cfg[i].en);
        end
        rd_data[BIT_MASTER] = ctl_q.master;
        rd_data[BIT_SWI]    = ctl_q.swi;
        irq_n               = ~(ctl_q.master & req_any);
    end
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] rd_data,
    input logic        irq_n
);
    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[6] |-> irq_n);                                        // R11
    AST_SWI_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6] && rd_data[7]) |-> !irq_n);                        // R12
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[11:10] == 2'b00);                                      // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:12] == 4'h0);                                       // R2
    AST_DIS_NO_ST1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> !rd_data[2]);                                  // R9
    AST_DIS_NO_ST2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3] |-> !rd_data[5]);                                  // R5
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_data[0] && rd_data[1] && rd_data[8] && rd_data[2]) |=> rd_data[2]); // R6
    AST_LVL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6] && rd_data[0] && rd_data[2]) |-> !irq_n);          // R10
endmodule

bind lirq_ctrl lirq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_data(rd_data),
    .irq_n  (irq_n)
);

// File: tb/sim_lirq_ctrl.sv
module sim_lirq_ctrl;
    localparam time CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  irq_in = '0;
    logic        irq_n;

    typedef struct {
        string       req;
        logic [15:0] rd;
        logic        irq;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    lirq_ctrl u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .irq_in (irq_in),
        .irq_n  (irq_n)
    );

    always #(CLK_PER/2) clk = ~clk;

    // monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (rd_data !== e.rd || irq_n !== e.irq) begin
                n_bad++;
                $display("FAIL %s: rd_data=%h irq_n=%b, expected rd_data=%h irq_n=%b",
                         e.req, rd_data, irq_n, e.rd, e.irq);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic expect_state(input string req, input logic [15:0] rd, input logic irq);
        exp_t e;
        e.req = req; e.rd = rd; e.irq = irq;
        exp_q.push_back(e);
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        expect_state("R1", 16'h0000, 1'b1);

        // R2 / R12: full write, clear bits dropped
        wr(16'hFFFF);
        expect_state("R2", 16'h03DB, 1'b0);
        wr(16'h0000);
        expect_state("R2", 16'h0000, 1'b1);

        // R3: active-high level on input 1, three-edge latency
        wr(16'h0043);
        irq_in[0] = 1'b1;
        tick(2);
        expect_state("R3", 16'h0043, 1'b1);
        expect_state("R3", 16'h0047, 1'b0);
        irq_in[0] = 1'b0;
        tick(3);
        expect_state("R5", 16'h0043, 1'b1);

        // R4: active-low level
        wr(16'h0041);
        expect_state("R4", 16'h0045, 1'b0);
        irq_in[0] = 1'b1;
        tick(3);
        expect_state("R4", 16'h0041, 1'b1);
        irq_in[0] = 1'b0;
        tick(3);
        expect_state("R4", 16'h0045, 1'b0);

        // R5: disable clears a level status in the same write
        wr(16'h0040);
        expect_state("R5", 16'h0040, 1'b1);

        // R6: edge-select without polarity stays in level mode
        wr(16'h0141);
        expect_state("R6", 16'h0145, 1'b0);
        irq_in[0] = 1'b1;
        tick(3);
        expect_state("R6", 16'h0141, 1'b1);

        // R6: qualified edge mode latches
        wr(16'h0143);
        expect_state("R6", 16'h0143, 1'b1);
        irq_in[0] = 1'b0;
        tick(3);
        expect_state("R6", 16'h0143, 1'b1);
        irq_in[0] = 1'b1;
        tick(3);
        expect_state("R6", 16'h0147, 1'b0);
        irq_in[0] = 1'b0;
        tick(3);
        expect_state("R6", 16'h0147, 1'b0);

        // R11: master off masks output, status still visible
        wr(16'h0103);
        expect_state("R11", 16'h0107, 1'b1);
        wr(16'h0143);
        expect_state("R10", 16'h0147, 1'b0);

        // R7: write-one clear
        wr(16'h0543);
        expect_state("R7", 16'h0143, 1'b1);

        // R8: clear and new rise on the same edge
        irq_in[0] = 1'b1;
        tick(3);
        expect_state("R6", 16'h0147, 1'b0);
        irq_in[0] = 1'b0;
        tick(3);
        irq_in[0] = 1'b1;
        tick(2);
        wr(16'h0543);
        expect_state("R8", 16'h0147, 1'b0);
        wr(16'h0543);
        expect_state("R7", 16'h0143, 1'b1);

        // R9: disabling an edge-mode input clears the latch
        irq_in[0] = 1'b0;
        tick(3);
        irq_in[0] = 1'b1;
        tick(3);
        expect_state("R9", 16'h0147, 1'b0);
        wr(16'h0142);
        expect_state("R9", 16'h0142, 1'b1);

        // input 2: level, master gate, edge, clear
        wr(16'h0058);
        irq_in[1] = 1'b1;
        tick(3);
        expect_state("R10", 16'h0078, 1'b0);
        wr(16'h0018);
        expect_state("R11", 16'h0038, 1'b1);
        irq_in[1] = 1'b0;
        tick(3);
        expect_state("R5", 16'h0018, 1'b1);
        wr(16'h0258);
        expect_state("R6", 16'h0258, 1'b1);
        irq_in[1] = 1'b1;
        tick(3);
        expect_state("R6", 16'h0278, 1'b0);
        wr(16'h0A58);
        expect_state("R7", 16'h0258, 1'b1);

        // R12: software request, gated by master
        wr(16'h0080);
        expect_state("R12", 16'h0080, 1'b1);
        wr(16'h00C0);
        expect_state("R12", 16'h00C0, 1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule